// File: doc/BRIEF.md
# System Reset Control Port

This block is a one-byte register on the I/O space that software writes to ask for a whole-system reset and to pick which kind of reset it wants. It watches the I/O address on every access. Only one fixed port address matches; every other address leaves the block untouched.

A write that matches the port and has the trigger bit set does not change the stored byte. It sends the system reset sequencer a request pulse that lasts one clock. A matching write without the trigger bit stores only the reset-type bit and clears every other bit. A matching read returns the stored byte in the same cycle. The port is a single byte, so byte order plays no part. The sequencer that acts on the request sits outside this block.

Top module: `rst_ctl_port`

## Requirements
- R1: After `rst_ni` is asserted, the stored byte is 0x00 and `sys_rst_req_o` is low.
- R2: The block responds only when the whole of `io_addr_i` equals 0x0CF9.
- R3: A write to 0x0CF9 with data bit 2 clear stores data bit 1 in bit 1 and clears bits 7..2 and bit 0. The result is 0x02 if data bit 1 was set, otherwise 0x00.
- R4: A write to 0x0CF9 with data bit 2 set drives `sys_rst_req_o` high in the clock cycle right after the write edge, for exactly that one cycle.
- R5: A write to 0x0CF9 with data bit 2 set leaves the stored byte unchanged.
- R6: While `io_rd_i` is high and the address is 0x0CF9, `io_rdata_o` shows the stored byte in the same cycle.
- R7: A write to any other address changes no stored bit and raises no request. A read at any other address returns 0x00.
- R8: Trigger writes on consecutive cycles each give one request cycle. The request drops on the cycle after the last trigger.
- R9: `sys_rst_req_o` is never high unless a trigger write was accepted on the edge before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O address of the access |
| io_wr_i | input | 1 | Write strobe, taken on the rising edge |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data byte |
| io_rdata_o | output | 8 | Read data, 0x00 when no read hits the port |
| sys_rst_req_o | output | 1 | One-cycle reset request to the sequencer |

## Verification
The bench writes bytes that mix the type bit with the other bits. A design that forgot the mask would return bits 0 or 3..7 on read-back. The bench also sends trigger writes that carry a new type bit. A design that updated the register on a trigger would then read back a changed value. The bench checks the request line on the cycle after the write edge and on the cycle after that. A stretched or delayed pulse fails one of those two samples. Near-miss addresses (0x0CF8, 0x0DF9) catch a partial address decode, and back-to-back triggers show whether the pulse logic merges or drops requests.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 8;
  localparam logic [15:0] PORT_ADDR = 16'h0CF9;
  localparam logic [7:0]  KEEP_MASK = 8'h02;
  localparam int unsigned TRIG_BIT  = 2;

  typedef struct packed {
    logic hit;
    logic store;
    logic trig;
    logic rd;
  } acc_t;
endpackage

// File: rtl/rst_ctl_decode.sv
module rst_ctl_decode
  import rst_ctl_pkg::*;
#(
  parameter int unsigned       AW   = ADDR_W,
  parameter logic [AW-1:0]     ADDR = AW'(PORT_ADDR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          trig_bit_i,
  output acc_t          acc_o
);
  always_comb begin
    acc_o.hit   = (addr_i == ADDR);
    acc_o.store = wr_i && acc_o.hit && !trig_bit_i;
    acc_o.trig  = wr_i && acc_o.hit && trig_bit_i;
    acc_o.rd    = rd_i && acc_o.hit;
  end

  // R5
  store_trig_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_o.store, acc_o.trig}));
endmodule

// File: rtl/rst_ctl_store.sv
module rst_ctl_store
  import rst_ctl_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R3
  store_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(d_i)));
  // R7
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/rst_ctl_pulse.sv
module rst_ctl_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= trig_i;
  end

  // R4
  pulse_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !trig_i) |=> !req_o);
  // R8
  pulse_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> req_o);
endmodule

// File: rtl/rst_ctl_port.sv
module rst_ctl_port
  import rst_ctl_pkg::*;
#(
  parameter int unsigned         AW    = ADDR_W,
  parameter int unsigned         DW    = DATA_W,
  parameter logic [AW-1:0]       ADDR  = AW'(PORT_ADDR),
  parameter logic [DW-1:0]       KEEP  = DW'(KEEP_MASK),
  parameter int unsigned         TBIT  = TRIG_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   io_addr_i,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  input  logic [7:0]    io_wdata_i,
  output logic [7:0]    io_rdata_o,
  output logic          sys_rst_req_o
);
  acc_t          acc;
  logic [DW-1:0] val_q;

  rst_ctl_decode #(.AW(AW), .ADDR(ADDR)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (io_addr_i),
    .wr_i       (io_wr_i),
    .rd_i       (io_rd_i),
    .trig_bit_i (io_wdata_i[TBIT]),
    .acc_o      (acc)
  );

  // only the reset-type bit survives a plain write
  rst_ctl_store #(.DW(DW)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (acc.store),
    .d_i    (io_wdata_i & KEEP),
    .q_o    (val_q)
  );

  rst_ctl_pulse u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (acc.trig),
    .req_o  (sys_rst_req_o)
  );

  assign io_rdata_o = acc.rd ? val_q : '0;

  // R9
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(io_wr_i && io_addr_i == ADDR && io_wdata_i[TBIT]));
  // R7
  miss_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i != ADDR) |-> (io_rdata_o == '0));
  // R3
  no_stray_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == ADDR) |-> ((io_rdata_o & ~KEEP) == '0));
  // R5
  trig_keeps_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == ADDR && io_wdata_i[TBIT]) |=> $stable(val_q));
endmodule

// File: tb/sim_rst_ctl_port.sv
module sim_rst_ctl_port;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        req;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_ctl_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr),
    .io_rd_i(rd), .io_wdata_i(wdata), .io_rdata_o(rdata), .sys_rst_req_o(req)
  );

  task automatic chk(string req_id, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  // one-cycle write; returns req sampled on the cycle after the edge
  task automatic wr_port(logic [15:0] a, logic [7:0] d, output logic req_after);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    req_after = req;
  endtask

  task automatic rd_port(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 req in reset", {7'b0, req}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd_port(16'h0CF9, v);
    chk("R1 value after reset", v, 8'h00);
    chk("R1 req after reset", {7'b0, req}, 8'h00);
  endtask

  task automatic t_store;
    logic r; logic [7:0] v;
    wr_port(16'h0CF9, 8'hFB, r); rd_port(16'h0CF9, v);
    chk("R3 write FB", v, 8'h02); chk("R3 no req on FB", {7'b0, r}, 8'h00);
    wr_port(16'h0CF9, 8'hF9, r); rd_port(16'h0CF9, v);
    chk("R3 write F9", v, 8'h00);
    wr_port(16'h0CF9, 8'h02, r); rd_port(16'h0CF9, v);
    chk("R6 write 02 read back", v, 8'h02);
    wr_port(16'h0CF9, 8'h01, r); rd_port(16'h0CF9, v);
    chk("R3 write 01", v, 8'h00);
  endtask

  task automatic t_trigger;
    logic r; logic [7:0] v;
    wr_port(16'h0CF9, 8'h02, r);
    wr_port(16'h0CF9, 8'h04, r);
    chk("R4 req after trigger", {7'b0, r}, 8'h01);
    @(negedge clk);
    chk("R4 req drops", {7'b0, req}, 8'h00);
    rd_port(16'h0CF9, v);
    chk("R5 trigger keeps 02", v, 8'h02);
    wr_port(16'h0CF9, 8'h00, r);
    wr_port(16'h0CF9, 8'hFF, r);
    chk("R4 req after FF", {7'b0, r}, 8'h01);
    rd_port(16'h0CF9, v);
    chk("R5 trigger keeps 00", v, 8'h00);
  endtask

  task automatic t_other_addr;
    logic r; logic [7:0] v;
    wr_port(16'h0CF9, 8'h02, r);
    wr_port(16'h0CF8, 8'h00, r); rd_port(16'h0CF9, v);
    chk("R7 write CF8 ignored", v, 8'h02);
    wr_port(16'h0DF9, 8'h04, r);
    chk("R2 no req at DF9", {7'b0, r}, 8'h00);
    wr_port(16'h8CF9, 8'h00, r); rd_port(16'h0CF9, v);
    chk("R2 write 8CF9 ignored", v, 8'h02);
    rd_port(16'h0CF8, v);
    chk("R7 read CF8 zero", v, 8'h00);
    @(negedge clk); addr = 16'h0CF9; #1;
    chk("R6 no read strobe zero", rdata, 8'h00);
  endtask

  task automatic t_back_to_back;
    logic [7:0] v;
    @(negedge clk);
    addr = 16'h0CF9; wdata = 8'h04; wr = 1'b1;
    @(negedge clk);
    chk("R8 first req", {7'b0, req}, 8'h01);
    wdata = 8'h06;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    chk("R8 second req", {7'b0, req}, 8'h01);
    @(negedge clk);
    chk("R8 req drops after last", {7'b0, req}, 8'h00);
    rd_port(16'h0CF9, v);
    chk("R5 back-to-back keeps value", v, 8'h02);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc > WDOG_CYC) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WDOG_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_store();
    t_trigger();
    t_other_addr();
    t_back_to_back();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule